// File: doc/BRIEF.md
# Calendar Update and Alarm Engine

This block keeps the calendar time of a real-time clock and shows it in seven byte-wide time registers that a host reads. It counts in plain binary inside. On every accepted once-per-second tick it first moves that count forward by one second, holds an update-in-progress indication for a fixed number of clock cycles, and then refreshes the visible registers in the format the host has chosen. That format is BCD or binary, with either a 12-hour or a 24-hour hour byte. When the refresh completes, the block compares the new time with three alarm bytes and pulses flag-set events toward a status register that lives outside this block.

The host bus, the status register itself and the divider that makes the periodic and one-second ticks sit outside. The host loads a new time by putting all seven bytes on `load_bytes` and pulsing `load_en`. Byte k of `load_bytes` and of `time_bytes` sits in bits [8k+7:8k]. The order is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. Byte k of `alarm_bytes` is the alarm for seconds (k=0), minutes (k=1) and hours (k=2). The year byte is an offset from the parameter `BASE_YEAR`, and that offset is used in the leap-year test.

Top module: `cal_update_engine`

## Requirements
- R1: A tick is accepted only when `osc_sel` equals 3'b010. With any other code the tick is dropped entirely: no time change, no `uip`, no flag events.
- R2: `uip` rises in the cycle after an accepted tick, unless `set_mode` is high. It stays high for `UIP_CYCLES` cycles and falls in the same cycle that `time_bytes` refreshes. Ticks that arrive while an update is pending are ignored.
- R3: Seconds and minutes wrap from 59 to 0. Hours wrap from 23 to 0. Day of week counts 1..7 and wraps from 7 to 1. Each wrap carries into the next field.
- R4: Day of month rolls to 1 after 31/30/28 days, chosen by month. February has 29 days when BASE_YEAR+year is divisible by 4 and is either not divisible by 100 or divisible by 400. Month wraps 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R5: With `bin_mode`=0 every byte is BCD: tens in bits 7:4, units in bits 3:0. With `bin_mode`=1 every byte is plain binary. Loaded bytes and alarm bytes are read in the same format.
- R6: With `h24_mode`=0 the hour byte holds hour mod 12 in bits 6:0, and bit 7 is set for hours 12..23. So noon reads 0x80 and midnight reads 0x00. On load, bit 7 adds 12 to the hour. With `h24_mode`=1 the hour byte holds 0..23.
- R7: A `load_en` pulse makes `time_bytes` equal to `load_bytes` from the next cycle on. The next update continues from the decoded loaded time.
- R8: While `set_mode` is high, `uip` is low (raising it clears a pending `uip`) and `time_bytes` is not refreshed. The internal time still advances, and the update-ended interrupt is suppressed.
- R9: When an update completes with `alarm_ie`=1, `af_set` and `irqf_set` pulse for one cycle if each of the three alarm bytes either has bits 7:6 = 2'b11 (don't care) or equals the new time in the current format. Bits 7:6 = 2'b10 alone is not a don't care.
- R10: Every completed update pulses `uf_set` for one cycle. If `update_ie`=1 and `set_mode`=0, `irqf_set` pulses with it.
- R11: Out-of-range loaded values do not lock up. A field at or above its limit rolls to its first legal value at its next increment and carries on, and an unknown month uses 31 days.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_sel | input | 3 | Oscillator control code; 3'b010 runs the calendar |
| set_mode | input | 1 | Host is setting the time |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode | input | 1 | 1 = 24-hour hour byte, 0 = 12-hour with PM bit |
| alarm_ie | input | 1 | Alarm interrupt enable |
| update_ie | input | 1 | Update-ended interrupt enable |
| load_en | input | 1 | One-cycle pulse that loads a new time |
| load_bytes | input | 56 | Seven time bytes to load |
| alarm_bytes | input | 24 | Alarm seconds, minutes and hours bytes |
| time_bytes | output | 56 | Seven visible time bytes |
| uip | output | 1 | Update in progress |
| af_set | output | 1 | Pulse: set alarm flag |
| uf_set | output | 1 | Pulse: set update-ended flag |
| irqf_set | output | 1 | Pulse: set interrupt-request flag |

## Verification
The calendar is driven from loaded times that sit one second before each carry boundary: a plain hour, the last second of a year, February in leap, century and common years, and a 30-day month. This separates every carry path and month length, including the century rule. The same rollovers are repeated in binary and in 12-hour mode, where a seconds value of 9→10 and the noon and midnight hour codes show which encoding is in force. The alarm is tried with an exact field match, with the two-bit don't-care, with one bit only of the don't-care, and with a mismatched hour, which tells the per-field wildcard apart from a global match. Stopped-oscillator codes, SET, a tick inside the UIP window and out-of-range loads each check that nothing advances or locks up when it should not.

// File: rtl/cal_engine_pkg.sv
package cal_engine_pkg;

  localparam int NFIELD = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int NALARM = 3;

  typedef logic [NFIELD-1:0][7:0] cal_vec_t;
  typedef logic [NALARM-1:0][7:0] alm_vec_t;

  typedef enum logic [0:0] {SEQ_IDLE, SEQ_WAIT} seq_state_e;

  // register byte -> binary value
  function automatic logic [7:0] from_reg(input logic [7:0] b, input logic bin);
    logic [7:0] v;
    v = 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    return bin ? b : v;
  endfunction

  // binary value -> register byte
  function automatic logic [7:0] to_reg(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = v / 8'd10;
    units = v % 8'd10;
    return bin ? v : {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [7:0] from_hour(input logic [7:0] b, input logic bin,
                                           input logic h24);
    logic [7:0] h;
    h = from_reg({1'b0, b[6:0]}, bin);
    if (!h24 && b[7]) h = h + 8'd12;
    return h;
  endfunction

  function automatic logic [7:0] to_hour(input logic [7:0] v, input logic bin,
                                         input logic h24);
    logic [7:0] lo;
    lo = to_reg(v % 8'd12, bin);
    return h24 ? to_reg(v, bin) : {(v >= 8'd12), lo[6:0]};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
    case (mon)
      8'd2:                    return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_engine_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  cal_vec_t cur,
  output cal_vec_t nxt
);

  localparam logic [15:0] BASE16 = 16'(BASE_YEAR);

  logic [15:0] full_year;
  logic        leap;
  logic [7:0]  dim;
  logic        c_min, c_hour, c_day, c_mon, c_year;

  assign full_year = BASE16 + 16'(cur[F_YEAR]);
  assign leap = (full_year % 16'd4 == 16'd0) &&
                ((full_year % 16'd100 != 16'd0) || (full_year % 16'd400 == 16'd0));
  assign dim = month_days(cur[F_MON], leap);

  always_comb begin
    nxt    = cur;
    c_min  = cur[F_SEC] >= 8'd59;
    c_hour = c_min  && (cur[F_MIN]  >= 8'd59);
    c_day  = c_hour && (cur[F_HOUR] >= 8'd23);
    c_mon  = c_day  && (cur[F_MDAY] >= dim);
    c_year = c_mon  && (cur[F_MON]  >= 8'd12);

    nxt[F_SEC] = c_min ? 8'd0 : cur[F_SEC] + 8'd1;
    if (c_min)  nxt[F_MIN]  = c_hour ? 8'd0 : cur[F_MIN] + 8'd1;
    if (c_hour) nxt[F_HOUR] = c_day  ? 8'd0 : cur[F_HOUR] + 8'd1;
    if (c_day) begin
      nxt[F_WDAY] = (cur[F_WDAY] >= 8'd7) ? 8'd1 : cur[F_WDAY] + 8'd1;
      nxt[F_MDAY] = c_mon ? 8'd1 : cur[F_MDAY] + 8'd1;
    end
    if (c_mon)  nxt[F_MON]  = c_year ? 8'd1 : cur[F_MON] + 8'd1;
    if (c_year) nxt[F_YEAR] = (cur[F_YEAR] >= 8'd99) ? 8'd0 : cur[F_YEAR] + 8'd1;
  end

endmodule

// File: rtl/cal_codec.sv
module cal_codec
  import cal_engine_pkg::*;
(
  input  cal_vec_t int_time,
  input  cal_vec_t raw_in,
  input  logic     bin,
  input  logic     h24,
  output cal_vec_t enc_out,
  output cal_vec_t dec_out
);

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    if (f == F_HOUR) begin : g_hour
      assign enc_out[f] = to_hour(int_time[f], bin, h24);
      assign dec_out[f] = from_hour(raw_in[f], bin, h24);
    end else begin : g_plain
      assign enc_out[f] = to_reg(int_time[f], bin);
      assign dec_out[f] = from_reg(raw_in[f], bin);
    end
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_engine_pkg::*;
(
  input  alm_vec_t alm,
  input  alm_vec_t now,
  input  logic     bin,
  input  logic     h24,
  output logic     hit
);

  logic [NALARM-1:0] fld_ok;

  for (genvar k = 0; k < NALARM; k++) begin : g_alm
    logic [7:0] want;
    if (k == F_HOUR) begin : g_hour
      assign want = from_hour(alm[k], bin, h24);
    end else begin : g_plain
      assign want = from_reg(alm[k], bin);
    end
    assign fld_ok[k] = (alm[k][7:6] == 2'b11) || (want == now[k]);
  end

  assign hit = &fld_ok;

endmodule

// File: rtl/update_seq.sv
module update_seq
  import cal_engine_pkg::*;
#(
  parameter int UIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ok,
  input  logic set_mode,
  output logic adv_en,
  output logic done,
  output logic busy,
  output logic uip
);

  localparam int CW = $clog2(UIP_CYCLES + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          uip_q, uip_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    uip_d   = uip_q;
    adv_en  = 1'b0;
    done    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (tick_ok) begin
          adv_en  = 1'b1;
          state_d = SEQ_WAIT;
          cnt_d   = '0;
          uip_d   = !set_mode;
        end
      end
      SEQ_WAIT: begin
        if (cnt_q == CW'(UIP_CYCLES - 1)) begin
          done    = 1'b1;
          state_d = SEQ_IDLE;
          uip_d   = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (set_mode) uip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      uip_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      uip_q   <= uip_d;
    end
  end

  assign busy = (state_q == SEQ_WAIT);
  assign uip  = uip_q;

  // R8: SET drops the update-in-progress indication
  p_set_blocks_uip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |=> !uip);

  // R2: an accepted tick always opens the pending window
  p_start_opens_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> busy);

endmodule

// File: rtl/cal_update_engine.sv
module cal_update_engine
  import cal_engine_pkg::*;
#(
  parameter int         BASE_YEAR  = 2000,
  parameter int         UIP_CYCLES = 8,
  parameter logic [2:0] RUN_CODE   = 3'b010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_tick,
  input  logic [2:0]           osc_sel,
  input  logic                 set_mode,
  input  logic                 bin_mode,
  input  logic                 h24_mode,
  input  logic                 alarm_ie,
  input  logic                 update_ie,
  input  logic                 load_en,
  input  logic [NFIELD*8-1:0]  load_bytes,
  input  logic [NALARM*8-1:0]  alarm_bytes,
  output logic [NFIELD*8-1:0]  time_bytes,
  output logic                 uip,
  output logic                 af_set,
  output logic                 uf_set,
  output logic                 irqf_set
);

  // year, month, day, weekday, hour, minute, second
  localparam cal_vec_t RESET_TIME = {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  cal_vec_t cur_q, cur_d;
  cal_vec_t reg_q, reg_d;
  cal_vec_t nxt_time, enc_time, dec_load;
  logic     af_q, af_d, uf_q, uf_d, irqf_q, irqf_d;
  logic     tick_ok, adv_en, done, busy, alarm_hit;

  assign tick_ok = sec_tick && (osc_sel == RUN_CODE);

  update_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_ok  (tick_ok),
    .set_mode (set_mode),
    .adv_en   (adv_en),
    .done     (done),
    .busy     (busy),
    .uip      (uip)
  );

  cal_advance #(.BASE_YEAR(BASE_YEAR)) u_adv (
    .cur (cur_q),
    .nxt (nxt_time)
  );

  cal_codec u_codec (
    .int_time (cur_q),
    .raw_in   (cal_vec_t'(load_bytes)),
    .bin      (bin_mode),
    .h24      (h24_mode),
    .enc_out  (enc_time),
    .dec_out  (dec_load)
  );

  alarm_match u_alarm (
    .alm (alm_vec_t'(alarm_bytes)),
    .now (cur_q[NALARM-1:0]),
    .bin (bin_mode),
    .h24 (h24_mode),
    .hit (alarm_hit)
  );

  always_comb begin
    cur_d = cur_q;
    if (load_en)     cur_d = dec_load;
    else if (adv_en) cur_d = nxt_time;

    reg_d = reg_q;
    if (load_en)                reg_d = cal_vec_t'(load_bytes);
    else if (done && !set_mode) reg_d = enc_time;

    af_d   = done && alarm_ie && alarm_hit;
    uf_d   = done;
    irqf_d = af_d || (done && update_ie && !set_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= RESET_TIME;
      reg_q  <= RESET_TIME;
      af_q   <= 1'b0;
      uf_q   <= 1'b0;
      irqf_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      reg_q  <= reg_d;
      af_q   <= af_d;
      uf_q   <= uf_d;
      irqf_q <= irqf_d;
    end
  end

  assign time_bytes = reg_q;
  assign af_set     = af_q;
  assign uf_set     = uf_q;
  assign irqf_set   = irqf_q;

  // R3: an advance always leaves a legal seconds count
  p_sec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !load_en |=> cur_q[F_SEC] <= 8'd59);

  // R2: a tick inside the pending window changes nothing
  p_tick_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && busy && !load_en |=> $stable(cur_q));

  // R9: the alarm flag is only raised together with an update end
  p_alarm_at_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    af_set |-> uf_set);

  // R10: update-ended event is a single-cycle pulse
  p_uf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uf_set |=> !uf_set);

  // R8: no refresh of visible bytes under SET
  p_no_refresh_in_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && set_mode && !load_en |=> $stable(time_bytes));

endmodule

// File: tb/test_cal_update_engine.sv
module test_cal_update_engine;

  localparam int CLK_PERIOD = 10;
  localparam int UIP_N      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [2:0]  osc_sel = 3'b010;
  logic        set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic        alarm_ie = 1'b0, update_ie = 1'b0, load_en = 1'b0;
  logic [55:0] load_bytes = '0;
  logic [23:0] alarm_bytes = 24'hC0C0C0;
  logic [55:0] time_bytes;
  logic        uip, af_set, uf_set, irqf_set;

  int checks = 0, errors = 0;
  int n_af = 0, n_uf = 0, n_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_update_engine #(.BASE_YEAR(2050), .UIP_CYCLES(UIP_N)) i_cal_update_engine (
    .clk, .rst_n, .sec_tick, .osc_sel, .set_mode, .bin_mode, .h24_mode,
    .alarm_ie, .update_ie, .load_en, .load_bytes, .alarm_bytes,
    .time_bytes, .uip, .af_set, .uf_set, .irqf_set
  );

  always @(negedge clk) if (rst_n) begin
    if (af_set)   n_af++;
    if (uf_set)   n_uf++;
    if (irqf_set) n_irq++;
  end

  function automatic logic [55:0] tv(input logic [7:0] yr, mo, md, wd, hr, mi, se);
    return {yr, mo, md, wd, hr, mi, se};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clr_cnt();
    n_af = 0; n_uf = 0; n_irq = 0;
  endtask

  task automatic load(input logic [55:0] t);
    @(negedge clk); load_bytes = t; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic one_second();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (UIP_N) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("reset R7 time", time_bytes, tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    chk("reset R2 uip", uip, 0);
  endtask

  task automatic t_rollover();
    load(tv(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59));
    #1 chk("R7 load visible", time_bytes, tv(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R3 R4 year end", time_bytes, tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    one_second();
    chk("R3 plain second", time_bytes, tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01));
    load(tv(8'h10, 8'h05, 8'h10, 8'h03, 8'h10, 8'h59, 8'h59));
    one_second();
    chk("R3 hour carry", time_bytes, tv(8'h10, 8'h05, 8'h10, 8'h03, 8'h11, 8'h00, 8'h00));
  endtask

  task automatic t_leap();
    load(tv(8'h54, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R4 leap feb28", time_bytes, tv(8'h54, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00));
    load(tv(8'h54, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R4 leap feb29", time_bytes, tv(8'h54, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
    load(tv(8'h50, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R4 century feb28", time_bytes, tv(8'h50, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
    load(tv(8'h51, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R4 common feb28", time_bytes, tv(8'h51, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
    load(tv(8'h51, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R4 april30", time_bytes, tv(8'h51, 8'h05, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_binary();
    bin_mode = 1'b1;
    load(tv(8'd30, 8'd6, 8'd30, 8'd2, 8'd23, 8'd59, 8'd59));
    one_second();
    chk("R5 binary rollover", time_bytes, tv(8'd30, 8'd7, 8'd1, 8'd3, 8'd0, 8'd0, 8'd0));
    load(tv(8'd30, 8'd7, 8'd1, 8'd3, 8'd5, 8'd6, 8'd9));
    one_second();
    chk("R5 binary 9->10", time_bytes, tv(8'd30, 8'd7, 8'd1, 8'd3, 8'd5, 8'd6, 8'd10));
    bin_mode = 1'b0;
    load(tv(8'h30, 8'h07, 8'h01, 8'h03, 8'h05, 8'h06, 8'h09));
    one_second();
    chk("R5 bcd 9->10", time_bytes, tv(8'h30, 8'h07, 8'h01, 8'h03, 8'h05, 8'h06, 8'h10));
  endtask

  task automatic t_12h();
    h24_mode = 1'b0;
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h11, 8'h59, 8'h59));
    one_second();
    chk("R6 noon", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h80, 8'h00, 8'h00));
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h91, 8'h59, 8'h59));
    one_second();
    chk("R6 midnight", time_bytes, tv(8'h20, 8'h03, 8'h16, 8'h03, 8'h00, 8'h00, 8'h00));
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h81, 8'h00, 8'h00));
    one_second();
    chk("R6 pm hour kept", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h81, 8'h00, 8'h01));
    h24_mode = 1'b1;
  endtask

  task automatic t_osc();
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h00));
    clr_cnt();
    osc_sel = 3'b000;
    one_second();
    chk("R1 stopped code 000 time", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h00));
    osc_sel = 3'b011;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    #1 chk("R1 no uip", uip, 0);
    repeat (UIP_N) @(negedge clk);
    #1 chk("R1 code 011 time", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h00));
    chk("R1 no uf", n_uf, 0);
    osc_sel = 3'b010;
    one_second();
    chk("R1 run resumes", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h01));
  endtask

  task automatic t_uip();
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h20));
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk);
    #1 chk("R2 uip rises", uip, 1);
    sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (UIP_N - 2) @(negedge clk);
    #1 chk("R2 uip held", uip, 1);
    chk("R2 old time in window", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h20));
    @(negedge clk);
    #1 chk("R2 uip falls", uip, 0);
    chk("R2 refreshed", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h21));
    repeat (2 * UIP_N) @(negedge clk);
    #1 chk("R2 extra tick ignored", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h21));
  endtask

  task automatic t_set();
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h10));
    update_ie = 1'b1; set_mode = 1'b1; clr_cnt();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    #1 chk("R8 no uip in set", uip, 0);
    repeat (UIP_N) @(negedge clk);
    #1 chk("R8 no refresh", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h10));
    chk("R8 uf still", n_uf, 1);
    chk("R8 irq suppressed", n_irq, 0);
    set_mode = 1'b0;
    one_second();
    chk("R8 counted under set", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h12));
    chk("R10 irq with uie", n_irq, 1);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; set_mode = 1'b1;
    @(negedge clk);
    #1 chk("R8 set clears uip", uip, 0);
    set_mode = 1'b0;
    repeat (UIP_N) @(negedge clk);
    update_ie = 1'b0;
  endtask

  task automatic t_uie();
    clr_cnt();
    one_second();
    chk("R10 uf pulse", n_uf, 1);
    chk("R10 no irq without uie", n_irq, 0);
  endtask

  task automatic t_alarm();
    alarm_ie = 1'b1;
    alarm_bytes = {8'hC0, 8'hC0, 8'h05};
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h12, 8'h30, 8'h03));
    clr_cnt();
    one_second();
    chk("R9 no alarm at 04", n_af, 0);
    one_second();
    chk("R9 alarm at 05", n_af, 1);
    chk("R9 irq with alarm", n_irq, 1);
    one_second();
    chk("R9 alarm once", n_af, 1);
    alarm_bytes = {8'h13, 8'hC0, 8'h05};
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h12, 8'h30, 8'h04));
    clr_cnt(); one_second();
    chk("R9 hour mismatch", n_af, 0);
    alarm_bytes = {8'h12, 8'h80, 8'h05};
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h12, 8'h30, 8'h04));
    clr_cnt(); one_second();
    chk("R9 half wildcard", n_af, 0);
    alarm_bytes = {8'h12, 8'h30, 8'h05};
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h12, 8'h30, 8'h04));
    clr_cnt(); one_second();
    chk("R9 full match", n_af, 1);
    alarm_ie = 1'b0;
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h12, 8'h30, 8'h04));
    clr_cnt(); one_second();
    chk("R9 disabled", n_af, 0);
    chk("R10 uf without alarm", n_uf, 1);
  endtask

  task automatic t_range();
    load(tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h05, 8'h10, 8'h75));
    one_second();
    chk("R11 sec 75", time_bytes, tv(8'h20, 8'h03, 8'h15, 8'h02, 8'h05, 8'h11, 8'h00));
    load(tv(8'h20, 8'h03, 8'h45, 8'h02, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R11 mday 45", time_bytes, tv(8'h20, 8'h04, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));
    load(tv(8'h20, 8'h15, 8'h31, 8'h09, 8'h23, 8'h59, 8'h59));
    one_second();
    chk("R11 month 15", time_bytes, tv(8'h21, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_rollover();
    t_leap();
    t_binary();
    t_12h();
    t_osc();
    t_uip();
    t_set();
    t_uie();
    t_alarm();
    t_range();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

endmodule